// File: doc/BRIEF.md
# Dual Compare Timer

This block holds two independent up-counting timers behind a small word-addressed register port. Each timer has three registers: control, compare and counter. While enabled, a timer adds one to its counter on every system clock. When the counter has reached the compare value, the timer raises its own interrupt line for one clock. It then either wraps to zero and keeps running, or turns itself off, depending on a control bit.

Software loads the compare value, optionally presets the counter, and sets the enable bit. A counter preset larger than the compare value is limited to the compare value. Read data is registered: `bus_rdata` shows the register addressed in the previous cycle, with the value that register held before that clock edge. Each timer occupies four word slots. The fourth slot of each group, and any group beyond the last timer, reads as zero and ignores writes.

Top module: `dual_cmp_timer`

## Requirements
- R1: After synchronous reset every register of both timers reads zero, both timers are stopped and both `irq` bits are low.
- R2: Timer t uses word addresses 4t+0 (control), 4t+1 (compare) and 4t+2 (counter). Word offset 3 within a group reads as zero and ignores writes. `bus_rdata` is registered, so it shows, one cycle after the address, the state from before that clock edge.
- R3: Control bit 0 is enable and control bit 1 is auto-restart. All other control bits are stored and read back as written, but have no effect on the timer.
- R4: While enable is set, the counter increases by one on each clock. While enable is clear, the counter holds its value.
- R5: While enabled, a timer whose counter is greater than or equal to its compare value is in a match cycle. The matching `irq` bit is high for exactly the one cycle that follows each match cycle.
- R6: On a match with auto-restart clear, hardware clears the enable bit and the counter stays at its current value.
- R7: On a match with auto-restart set, the counter becomes zero at the end of the match cycle and counting continues, so the interrupt period is compare+1 clocks.
- R8: A counter write whose value exceeds the compare value stores the compare value instead of the written value.
- R9: A compare write is used from the cycle after the write. Lowering the compare value below a running count gives a match in the cycle after the write.
- R10: The two timers are independent. Writes, counting and matches of one timer never change the other timer's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (3) | Word address for read and write |
| bus_we | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| irq | output | NUM_TIMERS (2) | One-cycle interrupt pulse per timer |

## Verification
The hardest case to reach from the ports is the exact cycle of each interrupt pulse relative to the write that starts a timer. This matters most with compare values of 0 and 1, where the counter matches again immediately after a restart. The bench sweeps every compare value from 0 to 5 in both one-shot and auto-restart mode, starting each run at a known clock edge. It then checks `irq` on every following cycle against an arithmetic period. Two timers running at once with coprime periods, and a compare value lowered under a running count, cover the remaining ordering cases.

// File: rtl/dct_pkg.sv
package dct_pkg;

    // control register bit positions
    localparam int EN_BIT = 0;
    localparam int AR_BIT = 1;

    // word offset of a register inside one timer's group of four
    typedef enum logic [1:0] {
        OFF_CTRL = 2'd0,
        OFF_CMP  = 2'd1,
        OFF_CNT  = 2'd2,
        OFF_NONE = 2'd3
    } reg_off_e;

    // per-timer write strobes
    typedef struct packed {
        logic ctrl;
        logic cmp;
        logic cnt;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_strobe(input logic we, input logic [1:0] off);
        wr_strobe_t s;
        s.ctrl = we && (reg_off_e'(off) == OFF_CTRL);
        s.cmp  = we && (reg_off_e'(off) == OFF_CMP);
        s.cnt  = we && (reg_off_e'(off) == OFF_CNT);
        return s;
    endfunction

endpackage

// File: rtl/dct_timer_unit.sv
module dct_timer_unit
    import dct_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              irq
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic              hit;
    logic [DATA_W-1:0] load_val;

    // a match is any enabled cycle where the count is at or past the limit
    assign hit      = ctrl_q[EN_BIT] && (cnt_q >= cmp_q);
    // counter writes are limited to the current compare value
    assign load_val = (wdata > cmp_q) ? cmp_q : wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            cnt_q  <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= hit;

            if (wr.ctrl) begin
                ctrl_q <= wdata;
            end else if (hit && !ctrl_q[AR_BIT]) begin
                ctrl_q[EN_BIT] <= 1'b0;
            end

            if (wr.cmp) begin
                cmp_q <= wdata;
            end

            if (wr.cnt) begin
                cnt_q <= load_val;
            end else if (hit) begin
                if (ctrl_q[AR_BIT]) begin
                    cnt_q <= '0;
                end
            end else if (ctrl_q[EN_BIT]) begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !ctrl_q[AR_BIT] && !wr.ctrl) |=> !ctrl_q[EN_BIT]);

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && ctrl_q[AR_BIT] && !wr.cnt) |=> (cnt_q == '0));

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[EN_BIT] && !wr.cnt) |=> $stable(cnt_q));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[EN_BIT] && (cnt_q < cmp_q) && !wr.cnt) |=> (cnt_q == $past(cnt_q) + ONE));

    // R8
    load_clip_chk: assert property (@(posedge clk) disable iff (rst)
        wr.cnt |=> (cnt_q <= $past(cmp_q)));

    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctrl_q[EN_BIT]));

endmodule

// File: rtl/dct_read_mux.sv
module dct_read_mux
    import dct_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_TIMERS-1:0][DATA_W-1:0] ctrl_v,
    input  logic [NUM_TIMERS-1:0][DATA_W-1:0] cmp_v,
    input  logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_v,
    output logic [DATA_W-1:0]                 rdata
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    reg_off_e          off;
    logic [DATA_W-1:0] rd_next;

    assign idx = addr[ADDR_W-1:2];
    assign off = reg_off_e'(addr[1:0]);

    always_comb begin
        rd_next = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (idx == IDX_W'(t)) begin
                unique case (off)
                    OFF_CTRL: rd_next = ctrl_v[t];
                    OFF_CMP:  rd_next = cmp_v[t];
                    OFF_CNT:  rd_next = cnt_v[t];
                    OFF_NONE: rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd_next;
        end
    end

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[1:0] == 2'd3) |=> (rdata == '0));

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = ((NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1) + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_TIMERS-1:0][DATA_W-1:0] ctrl_v;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] cmp_v;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_v;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
        wr_strobe_t strobe;

        assign strobe = decode_strobe(bus_we && (bus_addr[ADDR_W-1:2] == IDX_W'(t)),
                                      bus_addr[1:0]);

        dct_timer_unit #(
            .DATA_W (DATA_W)
        ) u_unit (
            .clk    (clk),
            .rst    (rst),
            .wr     (strobe),
            .wdata  (bus_wdata),
            .ctrl_q (ctrl_v[t]),
            .cmp_q  (cmp_v[t]),
            .cnt_q  (cnt_v[t]),
            .irq    (irq[t])
        );
    end

    dct_read_mux #(
        .NUM_TIMERS (NUM_TIMERS),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W)
    ) u_rmux (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .ctrl_v (ctrl_v),
        .cmp_v  (cmp_v),
        .cnt_v  (cnt_v),
        .rdata  (bus_rdata)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0));

endmodule

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dual_cmp_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // called at a negedge; returns the state from before the next posedge
    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_we   = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {30'b0, irq}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 32'h0);
        end

        // R3: spare control bits stored, no effect with enable clear
        wr(3'd0, 32'hFFFF_FFFC);
        rd(3'd0, v);
        check("R3 readback", v, 32'hFFFF_FFFC);
        repeat (5) @(negedge clk);
        rd(3'd2, v);
        check("R3 no count", v, 32'h0);
        wr(3'd1, 32'h1234_5678);
        rd(3'd1, v);
        check("R2 cmp0", v, 32'h1234_5678);

        // R2: unmapped slots
        wr(3'd3, 32'hDEAD_BEEF);
        wr(3'd7, 32'hCAFE_F00D);
        rd(3'd3, v);
        check("R2 off3", v, 32'h0);
        rd(3'd7, v);
        check("R2 off7", v, 32'h0);
        rd(3'd0, v);
        check("R2 ctrl0 kept", v, 32'hFFFF_FFFC);
        for (int a = 4; a < 7; a++) begin
            rd(3'(a), v);
            check("R2 timer1 untouched", v, 32'h0);
        end

        // R8: clip sweep
        wr(3'd1, 32'd50);
        for (int x = 0; x <= 60; x++) begin
            wr(3'd2, 32'(x));
            rd(3'd2, v);
            check("R8 clip", v, (x > 50) ? 32'd50 : 32'(x));
        end
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v);
        check("R8 clip max", v, 32'd50);

        // R4: counting and holding
        wr(3'd0, 32'h0);
        wr(3'd1, 32'd1000);
        wr(3'd2, 32'd10);
        wr(3'd0, 32'h1);
        for (int i = 0; i < 20; i++) begin
            rd(3'd2, v);
            check("R4 count", v, 32'(10 + i));
        end
        wr(3'd0, 32'h0);
        rd(3'd2, v);
        check("R4 stop", v, 32'd31);
        repeat (5) @(negedge clk);
        rd(3'd2, v);
        check("R4 hold", v, 32'd31);

        // R5 R6 R3: one-shot with spare bits set
        wr(3'd1, 32'd20);
        wr(3'd2, 32'd15);
        wr(3'd0, 32'hFFFF_FFFD);
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            check("R5 one-shot irq", {31'b0, irq[0]}, (n == 6) ? 32'd1 : 32'd0);
        end
        rd(3'd0, v);
        check("R6 enable cleared", v, 32'hFFFF_FFFC);
        rd(3'd2, v);
        check("R6 count held", v, 32'd20);

        // R6 R7: compare sweep in both modes
        for (int ar = 0; ar < 2; ar++) begin
            for (int c = 0; c <= 5; c++) begin
                wr(3'd0, 32'h0);
                wr(3'd1, 32'(c));
                wr(3'd2, 32'h0);
                wr(3'd0, (ar != 0) ? 32'h3 : 32'h1);
                for (int n = 1; n <= 14; n++) begin
                    @(negedge clk);
                    if (ar != 0)
                        check("R7 period", {31'b0, irq[0]}, ((n % (c + 1)) == 0) ? 32'd1 : 32'd0);
                    else
                        check("R6 single", {31'b0, irq[0]}, (n == c + 1) ? 32'd1 : 32'd0);
                end
                rd(3'd0, v);
                check((ar != 0) ? "R7 still enabled" : "R6 disabled", v, (ar != 0) ? 32'h3 : 32'h0);
                if (ar == 0) begin
                    rd(3'd2, v);
                    check("R6 final count", v, 32'(c));
                end
            end
        end

        // R9: lowering compare under a running count
        wr(3'd0, 32'h0);
        wr(3'd1, 32'd100);
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h1);
        repeat (10) @(negedge clk);
        wr(3'd1, 32'd5);
        check("R9 no irq yet", {31'b0, irq[0]}, 32'd0);
        @(negedge clk);
        check("R9 irq", {31'b0, irq[0]}, 32'd1);
        @(negedge clk);
        check("R9 irq ends", {31'b0, irq[0]}, 32'd0);
        rd(3'd2, v);
        check("R9 count", v, 32'd11);
        rd(3'd0, v);
        check("R9 stopped", v, 32'h0);

        // R10: timer 1 alone
        wr(3'd5, 32'd7);
        wr(3'd6, 32'h0);
        wr(3'd4, 32'h3);
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            check("R10 solo irq", {30'b0, irq}, ((n % 8) == 0) ? 32'h2 : 32'h0);
        end
        wr(3'd4, 32'h0);
        rd(3'd2, v);
        check("R10 timer0 count kept", v, 32'd11);
        rd(3'd1, v);
        check("R10 timer0 cmp kept", v, 32'd5);

        // R10 R7: both running with different periods
        wr(3'd1, 32'd2);
        wr(3'd2, 32'h0);
        wr(3'd5, 32'd4);
        wr(3'd6, 32'h0);
        wr(3'd0, 32'h3);
        wr(3'd4, 32'h3);
        for (int n = 2; n <= 21; n++) begin
            @(negedge clk);
            check("R10 irq0", {31'b0, irq[0]}, ((n % 3) == 0) ? 32'd1 : 32'd0);
            check("R10 irq1", {31'b0, irq[1]}, (((n - 1) % 5) == 0) ? 32'd1 : 32'd0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule